// File: doc/BRIEF.md
# CEC Host Register and Frame Interface

This block is the host-facing side of a consumer-electronics-control bridge. A host reaches a small set of byte registers over an abstract byte bus. It first loads an address pointer, and each data read or write then moves that pointer on by one. Two registers together form a 15-bit acknowledge mask that decides which incoming destination addresses are taken. A configuration register holds the error-report enable, the interrupt polarity and the retry count. A 19-byte window at pointer addresses 07h to 19h carries whole message frames in both directions.

An accepted incoming message is written into the frame buffer and raises the interrupt output. The host drains the frame from 07h, and the interrupt drops when the last byte has been read. To send a frame, the host writes it from 07h. The first byte is the count, then comes a service selector byte, then the parameter bytes. When the full count has arrived the frame is handed onward with a one-cycle valid pulse. An access that tries to start partway through the window is refused.

Top module: `cec_host_regs`

## Requirements
- R1: After reset the configuration register reads 05h (retry 5, active-low interrupt, error reports off), the mask registers read 00h, `retryCount` is 5 and `intOut` is 1 (inactive).
- R2: `ptrWr` loads the pointer from `ptrData`. Every bus read or write moves the pointer on by one. Read data appears on `rdData` on the cycle after `rdEn`. Address 04h is the mask-high register (bit 7 reads 0) and 05h is the mask-low register.
- R3: A message to destination n (0 to 14) is accepted only if mask bit n is set. Mask bits 14..8 are mask-high bits 6..0 and mask bits 7..0 are mask-low bits 7..0. Acceptance gives a `rxAck` pulse one cycle after `rxValid`.
- R4: A message to destination 15 (broadcast) is always accepted, whatever the mask.
- R5: An accepted message fills the frame: byte 0 = parameter count + 2, byte 1 = `rxOpcode`, then the parameters (byte at `rxParams[7:0]` first). A refused message leaves the interrupt unchanged.
- R6: The interrupt becomes pending one cycle after an accepted message. `intOut` shows pending at the level set by configuration bit 3 (0: low, 1: high). Reading frame byte index count-1 in a sequence begun at 07h clears it.
- R7: A read sequence starts only at 07h. A read of a data address above 07h outside a sequence returns 00h.
- R8: A write sequence begins with a count byte in the range 2..19 at 07h, followed by consecutive bytes. When the number of bytes written equals the count, `txValid` pulses on the next cycle and `txFrame` holds the frame, with byte k at bits 8k+7:8k.
- R9: A write to a data address above 07h with no write sequence open is not stored.
- R10: `errFlag` pulses on the cycle after a faulty access, but only when configuration bit 4 is 1. Faulty accesses are: a fragment read or write, a count byte outside 2..19, and an open write sequence cut off by a pointer load or an accepted message.
- R11: `retryCount` equals configuration bits 2..0 for values 0..5 and equals 5 for values 6 and 7.
- R12: Configuration bits 7..5 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrWr | input | 1 | Load address pointer |
| ptrData | input | 5 | New pointer value |
| wrEn | input | 1 | Write byte at pointer |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read byte at pointer |
| rdData | output | 8 | Read data, registered |
| rxValid | input | 1 | Incoming message present (one cycle) |
| rxDest | input | 4 | Incoming destination logical address |
| rxOpcode | input | 8 | Incoming service selector |
| rxNumParams | input | 5 | Incoming parameter count (above 17 taken as 17) |
| rxParams | input | 136 | Incoming parameters, first at bits 7:0 |
| rxAck | output | 1 | Message accepted pulse |
| intOut | output | 1 | Interrupt, polarity per configuration |
| errFlag | output | 1 | Error report pulse |
| retryCount | output | 3 | Effective retry count |
| txValid | output | 1 | Host frame complete pulse |
| txFrame | output | 152 | Frame buffer contents |

## Verification
The hardest situation to reach from the ports is a write sequence that is left open and then cut off. The bench gets there by loading a valid count at 07h, writing fewer bytes than that count, and then reloading the pointer. It then checks for an error pulse, and checks that none comes when error reports are off. Fragment accesses are set up by loading the pointer straight to 08h or 09h without going through 07h. Interrupt clearing is checked byte by byte through a full frame, once at each polarity.

// File: rtl/cec_host_pkg.sv
package cec_host_pkg;
  localparam int IDX_W = 5;

  typedef struct packed {
    logic regWr;
    logic regRd;
    logic bufWr;
    logic bufRd;
    logic zeroRd;
    logic loadRx;
    logic [IDX_W-1:0] idx;
  } ctrlStrobe_t;
endpackage

// File: rtl/cec_host_dpath.sv
module cec_host_dpath
  import cec_host_pkg::*;
#(
  parameter int FRAME_MAX = 19,
  parameter int PTR_W = 5,
  parameter int MAX_RETRY = 5,
  localparam int PARAM_MAX = FRAME_MAX - 2,
  localparam int NP_W = $clog2(PARAM_MAX + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobe_t st,
  input  logic [PTR_W-1:0] ptr,
  input  logic [7:0] wrData,
  input  logic [3:0] rxDest,
  input  logic [7:0] rxOpcode,
  input  logic [NP_W-1:0] rxNumParams,
  input  logic [PARAM_MAX*8-1:0] rxParams,
  output logic [7:0] rdData,
  output logic rxHit,
  output logic [7:0] frameLen,
  output logic errEn,
  output logic intPol,
  output logic [2:0] retryCount,
  output logic [FRAME_MAX*8-1:0] txFrame
);
  localparam logic [PTR_W-1:0] MASK_HI_ADDR = PTR_W'(4);
  localparam logic [PTR_W-1:0] MASK_LO_ADDR = PTR_W'(5);
  localparam logic [PTR_W-1:0] CFG_ADDR = PTR_W'(6);

  logic [6:0] maskHi;
  logic [7:0] maskLo;
  logic [4:0] cfg;
  logic [7:0] frameBuf [FRAME_MAX];
  logic [7:0] rxImage [FRAME_MAX];
  logic [NP_W-1:0] nClamp;
  logic [15:0] acceptVec;

  // Broadcast address 15 sits above the mask and is always taken
  assign acceptVec = {1'b1, maskHi, maskLo};
  assign rxHit = acceptVec[rxDest];

  assign errEn = cfg[4];
  assign intPol = cfg[3];
  assign retryCount = (cfg[2:0] > 3'(MAX_RETRY)) ? 3'(MAX_RETRY) : cfg[2:0];
  assign frameLen = frameBuf[0];

  assign nClamp = (rxNumParams > NP_W'(PARAM_MAX)) ? NP_W'(PARAM_MAX) : rxNumParams;

  always_comb begin
    rxImage[0] = 8'(nClamp) + 8'd2;
    rxImage[1] = rxOpcode;
    for (int i = 0; i < PARAM_MAX; i++) begin
      rxImage[i+2] = (i < int'(nClamp)) ? rxParams[i*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskHi <= '0;
      maskLo <= '0;
      cfg <= 5'b00101;
    end else if (st.regWr) begin
      case (ptr)
        MASK_HI_ADDR: maskHi <= wrData[6:0];
        MASK_LO_ADDR: maskLo <= wrData;
        CFG_ADDR: cfg <= wrData[4:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FRAME_MAX; i++) frameBuf[i] <= '0;
    end else if (st.loadRx) begin
      for (int i = 0; i < FRAME_MAX; i++) frameBuf[i] <= rxImage[i];
    end else if (st.bufWr) begin
      frameBuf[st.idx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (st.bufRd) begin
      rdData <= frameBuf[st.idx];
    end else if (st.zeroRd) begin
      rdData <= '0;
    end else if (st.regRd) begin
      case (ptr)
        MASK_HI_ADDR: rdData <= {1'b0, maskHi};
        MASK_LO_ADDR: rdData <= maskLo;
        CFG_ADDR: rdData <= {3'b000, cfg};
        default: rdData <= '0;
      endcase
    end
  end

  for (genvar g = 0; g < FRAME_MAX; g++) begin : gTx
    assign txFrame[g*8 +: 8] = frameBuf[g];
  end

  AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rstN)
    retryCount <= 3'(MAX_RETRY)); // R11
  AST_CFG_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    st.regRd && ptr == CFG_ADDR |=> rdData[7:5] == 3'b000); // R12
  AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    st.loadRx |=> frameBuf[0] >= 8'd2); // R5
endmodule

// File: rtl/cec_host_ctrl.sv
module cec_host_ctrl
  import cec_host_pkg::*;
#(
  parameter int FRAME_MAX = 19,
  parameter int PTR_W = 5,
  parameter int DATA_BASE = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic ptrWr,
  input  logic [PTR_W-1:0] ptrData,
  input  logic wrEn,
  input  logic [7:0] wrData,
  input  logic rdEn,
  input  logic rxValid,
  input  logic rxHit,
  input  logic [7:0] frameLen,
  input  logic errEn,
  output ctrlStrobe_t st,
  output logic [PTR_W-1:0] ptr,
  output logic intActive,
  output logic errFlag,
  output logic txValid,
  output logic rxAck
);
  localparam logic [PTR_W-1:0] BASE = PTR_W'(DATA_BASE);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DATA_BASE + FRAME_MAX);

  logic wrSeq, wrSeqN, rdSeq, rdSeqN, intN;
  logic [7:0] wrCnt, wrCntN, wrLen, wrLenN, rdCnt, rdCntN;
  logic [PTR_W-1:0] ptrN, idx;
  logic inData, doWr, doRd, rxTake, errNow, commitNow;

  assign inData = (ptr >= BASE) && (ptr < LIMIT);
  assign idx = ptr - BASE;
  assign doWr = !ptrWr && wrEn;
  assign doRd = !ptrWr && !wrEn && rdEn;
  assign rxTake = rxValid && rxHit;

  always_comb begin
    st = '0;
    st.idx = IDX_W'(idx);
    wrSeqN = wrSeq;
    wrCntN = wrCnt;
    wrLenN = wrLen;
    rdSeqN = rdSeq;
    rdCntN = rdCnt;
    intN = intActive;
    errNow = 1'b0;
    commitNow = 1'b0;
    ptrN = ptr;

    if (ptrWr) begin
      ptrN = ptrData;
      if (wrSeq) errNow = 1'b1;
      wrSeqN = 1'b0;
      rdSeqN = 1'b0;
    end else if (doWr) begin
      ptrN = ptr + 1'b1;
      if (!inData) begin
        st.regWr = 1'b1;
      end else if (!rxTake) begin
        if (idx == '0) begin
          if (wrData >= 8'd2 && wrData <= 8'(FRAME_MAX)) begin
            st.bufWr = 1'b1;
            wrSeqN = 1'b1;
            wrCntN = 8'd1;
            wrLenN = wrData;
            rdSeqN = 1'b0;
          end else begin
            errNow = 1'b1;
            wrSeqN = 1'b0;
          end
        end else if (wrSeq && 8'(idx) == wrCnt) begin
          st.bufWr = 1'b1;
          wrCntN = wrCnt + 8'd1;
          if (wrCnt + 8'd1 == wrLen) begin
            commitNow = 1'b1;
            wrSeqN = 1'b0;
          end
        end else begin
          errNow = 1'b1;
          wrSeqN = 1'b0;
        end
      end
    end else if (doRd) begin
      ptrN = ptr + 1'b1;
      if (!inData) begin
        st.regRd = 1'b1;
      end else if (rxTake) begin
        st.zeroRd = 1'b1;
      end else if (idx == '0) begin
        st.bufRd = 1'b1;
        rdSeqN = 1'b1;
        rdCntN = 8'd1;
        if (frameLen <= 8'd1) begin
          intN = 1'b0;
          rdSeqN = 1'b0;
        end
      end else if (rdSeq && 8'(idx) == rdCnt) begin
        st.bufRd = 1'b1;
        rdCntN = rdCnt + 8'd1;
        if (8'(idx) + 8'd1 == frameLen) begin
          intN = 1'b0;
          rdSeqN = 1'b0;
        end
      end else begin
        st.zeroRd = 1'b1;
        errNow = 1'b1;
        rdSeqN = 1'b0;
      end
    end

    // An accepted message takes the buffer and overrides any sequence
    if (rxTake) begin
      st.loadRx = 1'b1;
      if (wrSeq) errNow = 1'b1;
      wrSeqN = 1'b0;
      rdSeqN = 1'b0;
      intN = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      wrSeq <= 1'b0;
      wrCnt <= '0;
      wrLen <= '0;
      rdSeq <= 1'b0;
      rdCnt <= '0;
      intActive <= 1'b0;
      errFlag <= 1'b0;
      txValid <= 1'b0;
      rxAck <= 1'b0;
    end else begin
      ptr <= ptrN;
      wrSeq <= wrSeqN;
      wrCnt <= wrCntN;
      wrLen <= wrLenN;
      rdSeq <= rdSeqN;
      rdCnt <= rdCntN;
      intActive <= intN;
      errFlag <= errNow && errEn;
      txValid <= commitNow;
      rxAck <= rxTake;
    end
  end

  AST_NO_FRAG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    doWr && inData && idx != '0 && !wrSeq |-> !st.bufWr); // R9
  AST_INT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxHit |=> intActive); // R6
  AST_TX_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(wrEn)); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || rdEn) && !ptrWr |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R2
endmodule

// File: rtl/cec_host_regs.sv
module cec_host_regs
  import cec_host_pkg::*;
#(
  parameter int FRAME_MAX = 19,
  parameter int PTR_W = 5,
  parameter int DATA_BASE = 7,
  parameter int MAX_RETRY = 5,
  localparam int PARAM_MAX = FRAME_MAX - 2,
  localparam int NP_W = $clog2(PARAM_MAX + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic ptrWr,
  input  logic [PTR_W-1:0] ptrData,
  input  logic wrEn,
  input  logic [7:0] wrData,
  input  logic rdEn,
  output logic [7:0] rdData,
  input  logic rxValid,
  input  logic [3:0] rxDest,
  input  logic [7:0] rxOpcode,
  input  logic [NP_W-1:0] rxNumParams,
  input  logic [PARAM_MAX*8-1:0] rxParams,
  output logic rxAck,
  output logic intOut,
  output logic errFlag,
  output logic [2:0] retryCount,
  output logic txValid,
  output logic [FRAME_MAX*8-1:0] txFrame
);
  ctrlStrobe_t st;
  logic [PTR_W-1:0] ptr;
  logic rxHit, errEn, intPol, intActive;
  logic [7:0] frameLen;

  cec_host_ctrl #(.FRAME_MAX(FRAME_MAX), .PTR_W(PTR_W), .DATA_BASE(DATA_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .ptrWr(ptrWr), .ptrData(ptrData), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rxValid(rxValid), .rxHit(rxHit),
    .frameLen(frameLen), .errEn(errEn), .st(st), .ptr(ptr),
    .intActive(intActive), .errFlag(errFlag), .txValid(txValid), .rxAck(rxAck)
  );

  cec_host_dpath #(.FRAME_MAX(FRAME_MAX), .PTR_W(PTR_W), .MAX_RETRY(MAX_RETRY)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .ptr(ptr), .wrData(wrData),
    .rxDest(rxDest), .rxOpcode(rxOpcode), .rxNumParams(rxNumParams),
    .rxParams(rxParams), .rdData(rdData), .rxHit(rxHit), .frameLen(frameLen),
    .errEn(errEn), .intPol(intPol), .retryCount(retryCount), .txFrame(txFrame)
  );

  assign intOut = intPol ? intActive : !intActive;

  AST_BCAST_ACK: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxDest == 4'hF |=> rxAck); // R4
  AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(errEn)); // R10
endmodule

// File: tb/tb_cec_host_regs.sv
module tb_cec_host_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ptrWr = 1'b0;
  logic [4:0] ptrData = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [7:0] rdData;
  logic rxValid = 1'b0;
  logic [3:0] rxDest = '0;
  logic [7:0] rxOpcode = '0;
  logic [4:0] rxNumParams = '0;
  logic [135:0] rxParams = '0;
  logic rxAck, intOut, errFlag, txValid;
  logic [2:0] retryCount;
  logic [151:0] txFrame;

  int nChecks = 0;
  int nFail = 0;
  logic lastErr, lastTx, lastAck;
  logic [7:0] rd;

  // {write value, expected readback, expected retry}
  localparam logic [18:0] CFG_VEC [7] = '{
    {8'h00, 8'h00, 3'd0}, {8'h03, 8'h03, 3'd3}, {8'h06, 8'h06, 3'd5},
    {8'h07, 8'h07, 3'd5}, {8'hE4, 8'h04, 3'd4}, {8'hFF, 8'h1F, 3'd5},
    {8'hA5, 8'h05, 3'd5}
  };

  cec_host_regs dut (
    .clk(clk), .rstN(rstN), .ptrWr(ptrWr), .ptrData(ptrData), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .rxValid(rxValid),
    .rxDest(rxDest), .rxOpcode(rxOpcode), .rxNumParams(rxNumParams),
    .rxParams(rxParams), .rxAck(rxAck), .intOut(intOut), .errFlag(errFlag),
    .retryCount(retryCount), .txValid(txValid), .txFrame(txFrame)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishOp();
    @(negedge clk);
    lastErr = errFlag;
    lastTx = txValid;
    lastAck = rxAck;
    ptrWr = 1'b0; wrEn = 1'b0; rdEn = 1'b0; rxValid = 1'b0;
  endtask

  task automatic setPtr(input logic [4:0] p);
    ptrWr = 1'b1; ptrData = p;
    finishOp();
  endtask

  task automatic writeByte(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    finishOp();
  endtask

  task automatic readByte(output logic [7:0] d);
    rdEn = 1'b1;
    finishOp();
    d = rdData;
  endtask

  task automatic sendMsg(input logic [3:0] dest, input logic [7:0] op,
                         input logic [4:0] n, input logic [15:0] prm);
    rxValid = 1'b1; rxDest = dest; rxOpcode = op; rxNumParams = n;
    rxParams = '0; rxParams[15:0] = prm;
    finishOp();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 intOut", 32'(intOut), 32'h1);
    chk("R1 retryCount", 32'(retryCount), 32'd5);
    setPtr(5'd6); readByte(rd);
    chk("R1 cfg", 32'(rd), 32'h05);
    setPtr(5'd4); readByte(rd);
    chk("R1 maskHi", 32'(rd), 32'h00);

    // R11 R12 configuration table
    foreach (CFG_VEC[i]) begin
      setPtr(5'd6); writeByte(CFG_VEC[i][18:11]);
      chk("R11 retry", 32'(retryCount), 32'(CFG_VEC[i][2:0]));
      setPtr(5'd6); readByte(rd);
      chk("R12 cfg readback", 32'(rd), 32'(CFG_VEC[i][10:3]));
    end

    // R2 mask registers with pointer advance
    setPtr(5'd4); writeByte(8'h81); writeByte(8'h04);
    setPtr(5'd4); readByte(rd);
    chk("R2 maskHi", 32'(rd), 32'h01);
    readByte(rd);
    chk("R2 maskLo autoinc", 32'(rd), 32'h04);

    // R3 R5 refused and accepted messages
    sendMsg(4'd3, 8'h10, 5'd0, 16'h0);
    chk("R3 dest3 refused", 32'(lastAck), 32'h0);
    chk("R5 no int", 32'(intOut), 32'h1);
    sendMsg(4'd2, 8'h44, 5'd2, 16'hA2A1);
    chk("R3 dest2 accepted", 32'(lastAck), 32'h1);
    chk("R6 int low", 32'(intOut), 32'h0);

    // R7 R10 fragment read, reports off then on
    setPtr(5'd9); readByte(rd);
    chk("R7 fragment read", 32'(rd), 32'h00);
    chk("R10 err off", 32'(lastErr), 32'h0);
    setPtr(5'd6); writeByte(8'h15);
    setPtr(5'd9); readByte(rd);
    chk("R7 fragment read2", 32'(rd), 32'h00);
    chk("R10 err on", 32'(lastErr), 32'h1);

    // R5 R6 drain frame
    setPtr(5'd7); readByte(rd);
    chk("R5 count", 32'(rd), 32'h04);
    readByte(rd);
    chk("R5 opcode", 32'(rd), 32'h44);
    readByte(rd);
    chk("R5 param0", 32'(rd), 32'hA1);
    chk("R6 still pending", 32'(intOut), 32'h0);
    readByte(rd);
    chk("R5 param1", 32'(rd), 32'hA2);
    chk("R6 cleared", 32'(intOut), 32'h1);

    // R4 broadcast, R6 active-high polarity
    sendMsg(4'd15, 8'h36, 5'd0, 16'h0);
    chk("R4 broadcast ack", 32'(lastAck), 32'h1);
    chk("R6 pending low", 32'(intOut), 32'h0);
    setPtr(5'd6); writeByte(8'h1D);
    chk("R6 pending high", 32'(intOut), 32'h1);
    setPtr(5'd7); readByte(rd);
    chk("R5 bcast count", 32'(rd), 32'h02);
    readByte(rd);
    chk("R5 bcast opcode", 32'(rd), 32'h36);
    chk("R6 cleared high", 32'(intOut), 32'h0);

    // R3 upper mask register
    sendMsg(4'd8, 8'h01, 5'd0, 16'h0);
    chk("R3 dest8 accepted", 32'(lastAck), 32'h1);
    sendMsg(4'd9, 8'h01, 5'd0, 16'h0);
    chk("R3 dest9 refused", 32'(lastAck), 32'h0);

    // R8 host frame write
    setPtr(5'd7); writeByte(8'h03);
    chk("R8 no early tx0", 32'(lastTx), 32'h0);
    writeByte(8'h11);
    chk("R8 no early tx1", 32'(lastTx), 32'h0);
    writeByte(8'h22);
    chk("R8 tx pulse", 32'(lastTx), 32'h1);
    chk("R8 tx frame", 32'(txFrame[23:0]), 32'h221103);

    // R9 fragment write
    setPtr(5'd8); writeByte(8'h99);
    chk("R9 err", 32'(lastErr), 32'h1);
    chk("R9 no tx", 32'(lastTx), 32'h0);
    chk("R9 not stored", 32'(txFrame[15:8]), 32'h11);

    // R10 bad count and abandoned sequence
    setPtr(5'd7); writeByte(8'h01);
    chk("R10 bad count", 32'(lastErr), 32'h1);
    chk("R10 bad count not stored", 32'(txFrame[7:0]), 32'h03);
    setPtr(5'd7); writeByte(8'h04);
    chk("R10 good count", 32'(lastErr), 32'h0);
    writeByte(8'h55);
    setPtr(5'd7);
    chk("R10 abandoned", 32'(lastErr), 32'h1);
    setPtr(5'd6); writeByte(8'h05);
    setPtr(5'd8); writeByte(8'h77);
    chk("R10 suppressed", 32'(lastErr), 32'h0);
    chk("R9 not stored2", 32'(txFrame[15:8]), 32'h55);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule